// File: doc/BRIEF.md
# Guarded Interrupt Vector Relocation Control

This block holds a control byte that decides where the interrupt vector table sits. The table is either at word address zero or at the first word of the boot-loader region. A two-bit region-size code sets where the boot-loader region starts. The block computes the table base and the word address of the vector for the interrupt index the interrupt controller presents. Each vector entry occupies two words.

The table-select bit is protected by a timed unlock. Software first writes the byte with the unlock bit set, which opens a window a few cycles long. Inside that window it writes the new select value with the unlock bit clear. While the unlock sequence runs, the block raises an interrupt-hold output to the interrupt controller. The block never touches the core's global interrupt-enable flag. It only gates acceptance. Two boot-lock inputs (active low, so 0 means programmed) can also hold interrupts, depending on where the table sits and which region is executing. The six upper bits of the byte are plain read/write storage.

Top module: `vector_relocate_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, vec_base is 0 and irq_block is 0 when both lock inputs are 1.
- R2: With select (rd_data bit 1) at 0, vec_base is 0. With select at 1, vec_base is 0xF000, 0xF800, 0xFC00 or 0xFE00 for boot_size codes 0, 1, 2 and 3.
- R3: A write with bit 0 = 0, accepted while the unlock bit (rd_data bit 0) is 1, loads wr_data bit 1 into select and clears the unlock bit.
- R4: A write with bit 0 = 1 sets the unlock bit from the next cycle on, and irq_block is 1 in every cycle in which the unlock bit reads 1.
- R5: If no write arrives, the unlock bit stays 1 for exactly 4 cycles and then clears by itself. The hold it caused ends in the same cycle.
- R6: After an accepted select write, irq_block stays 1 until the first instr_done pulse that comes after the write cycle. It is 0 from the cycle after that pulse.
- R7: A write with bit 0 = 0 while the unlock bit is 0, or any write with bit 0 = 1, leaves select unchanged.
- R8: Every write stores wr_data bits 7:2 into rd_data bits 7:2.
- R9: vec_addr equals vec_base plus twice irq_index, modulo 2^16.
- R10: With select 1, lock_app_n 0 and in_boot 0, irq_block is 1.
- R11: With select 0, lock_boot_n 0 and in_boot 1, irq_block is 1. Outside R4, R6, R10 and R11, irq_block is 0.
- R12: A write with bit 0 = 1 while the window is open restarts the 4-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Byte written to the control register |
| instr_done | input | 1 | One-cycle pulse when an instruction completes |
| boot_size | input | 2 | Boot region size code |
| lock_app_n | input | 1 | Lock that guards the application region, 0 = programmed |
| lock_boot_n | input | 1 | Lock that guards the boot region, 0 = programmed |
| in_boot | input | 1 | Execution is currently in the boot region |
| irq_index | input | 6 | Index of the interrupt being vectored |
| rd_data | output | 8 | Control byte readback |
| vec_base | output | 16 | Word address of the vector table |
| vec_addr | output | 16 | Word address of the selected vector |
| irq_block | output | 1 | Interrupt acceptance hold |

## Verification
The assertions check several rules on every cycle. Select moves only after a write accepted inside an open window. An idle window closes when its count runs out. A pending hold drops after the completing instruction. An open window, or either lock condition, always raises the hold. The base is zero whenever select is clear. Only the bench scenarios show the window boundary: a write 3 cycles after unlock is accepted, a write 4 cycles after is not, and a re-armed window extends the deadline. The bench also covers the exact release cycle of the hold, storage of the upper bits, and the full address arithmetic over every size code and every index.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
    localparam int CE_BIT   = 0;
    localparam int SEL_BIT  = 1;
    localparam int MISC_LO  = 2;
    localparam int BYTE_W   = 8;
    localparam int SIZE_CODES = 4;
endpackage

// File: rtl/vrc_unlock.sv
module vrc_unlock
    import vrc_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              instr_done,
    output logic [BYTE_W-1:0] ctrl_byte,
    output logic              sel,
    output logic              auto_block
);
    localparam int CNT_W  = $clog2(WINDOW + 1);
    localparam int MISC_W = BYTE_W - MISC_LO;

    typedef struct packed {
        logic [MISC_W-1:0] misc;
        logic              sel;
        logic              ce;
        logic [CNT_W-1:0]  cnt;
        logic              post;
    } unlock_t;

    unlock_t state_d, state_q;
    logic    accept;

    always_comb begin
        state_d = state_q;
        accept  = wr_en && state_q.ce && !wr_data[CE_BIT];
        if (state_q.post && instr_done) begin
            state_d.post = 1'b0;
        end
        if (wr_en) begin
            state_d.misc = wr_data[BYTE_W-1:MISC_LO];
            if (wr_data[CE_BIT]) begin
                state_d.ce  = 1'b1;
                state_d.cnt = CNT_W'(WINDOW);
            end else begin
                if (accept) begin
                    state_d.sel  = wr_data[SEL_BIT];
                    state_d.post = 1'b1;
                end
                state_d.ce  = 1'b0;
                state_d.cnt = '0;
            end
        end else if (state_q.ce) begin
            if (state_q.cnt == CNT_W'(1)) begin
                state_d.ce  = 1'b0;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_byte  = {state_q.misc, state_q.sel, state_q.ce};
    assign sel        = state_q.sel;
    assign auto_block = state_q.ce | state_q.post;

    AST_SEL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q.sel) |-> $past(state_q.ce && wr_en && !wr_data[CE_BIT])); // R3 R7

    AST_WINDOW_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ce && state_q.cnt == CNT_W'(1) && !wr_en) |=> !state_q.ce); // R5

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.post && instr_done && !(wr_en && state_q.ce && !wr_data[CE_BIT]))
        |=> !state_q.post); // R6
endmodule

// File: rtl/vrc_vector.sv
module vrc_vector
    import vrc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 6,
    parameter int BOOT_MAX  = 4096
) (
    input  logic              sel,
    input  logic [1:0]        boot_size,
    input  logic [IDX_W-1:0]  irq_index,
    output logic [ADDR_W-1:0] vec_base,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(1) << ADDR_W;

    logic [ADDR_W-1:0] start_tab [SIZE_CODES];

    for (genvar g = 0; g < SIZE_CODES; g++) begin : g_start
        assign start_tab[g] = ADDR_W'(SPAN - ((ADDR_W+1)'(BOOT_MAX) >> g));
    end

    always_comb begin
        vec_base = sel ? start_tab[boot_size] : '0;
        vec_addr = vec_base + (ADDR_W'(irq_index) << 1);
    end
endmodule

// File: rtl/vrc_lockgate.sv
module vrc_lockgate (
    input  logic sel,
    input  logic in_boot,
    input  logic lock_app_n,
    input  logic lock_boot_n,
    input  logic auto_block,
    output logic irq_block
);
    logic app_guard, boot_guard;

    always_comb begin
        app_guard  = sel  && !lock_app_n  && !in_boot;
        boot_guard = !sel && !lock_boot_n && in_boot;
        irq_block  = auto_block | app_guard | boot_guard;
    end
endmodule

// File: rtl/vector_relocate_ctrl.sv
module vector_relocate_ctrl
    import vrc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 6,
    parameter int WINDOW   = 4,
    parameter int BOOT_MAX = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              instr_done,
    input  logic [1:0]        boot_size,
    input  logic              lock_app_n,
    input  logic              lock_boot_n,
    input  logic              in_boot,
    input  logic [IDX_W-1:0]  irq_index,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] vec_base,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              irq_block
);
    logic sel, auto_block;

    vrc_unlock #(.WINDOW(WINDOW)) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .instr_done (instr_done),
        .ctrl_byte  (rd_data),
        .sel        (sel),
        .auto_block (auto_block)
    );

    vrc_vector #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BOOT_MAX(BOOT_MAX)) u_vector (
        .sel       (sel),
        .boot_size (boot_size),
        .irq_index (irq_index),
        .vec_base  (vec_base),
        .vec_addr  (vec_addr)
    );

    vrc_lockgate u_gate (
        .sel         (sel),
        .in_boot     (in_boot),
        .lock_app_n  (lock_app_n),
        .lock_boot_n (lock_boot_n),
        .auto_block  (auto_block),
        .irq_block   (irq_block)
    );

    AST_UNLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CE_BIT] |-> irq_block); // R4

    AST_APP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[SEL_BIT] && !lock_app_n && !in_boot) |-> irq_block); // R10

    AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[SEL_BIT] && !lock_boot_n && in_boot) |-> irq_block); // R11

    AST_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[SEL_BIT] |-> (vec_base == '0)); // R2
endmodule

// File: tb/tb_vector_relocate_ctrl.sv
module tb_vector_relocate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       instr_done;
    logic [1:0] boot_size;
    logic       lock_app_n, lock_boot_n, in_boot;
    logic [5:0] irq_index;
    logic [7:0] rd_data;
    logic [15:0] vec_base, vec_addr;
    logic       irq_block;

    int errors = 0;
    int checks = 0;
    logic exp_sel;

    always #10 clk = ~clk;

    vector_relocate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .instr_done(instr_done), .boot_size(boot_size),
        .lock_app_n(lock_app_n), .lock_boot_n(lock_boot_n), .in_boot(in_boot),
        .irq_index(irq_index), .rd_data(rd_data), .vec_base(vec_base),
        .vec_addr(vec_addr), .irq_block(irq_block)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic set_sel(input logic v);
        wr(8'h01);
        wr({6'h0, v, 1'b0});
        pulse_done();
        exp_sel = v;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; instr_done = 1'b0;
        boot_size = '0; lock_app_n = 1'b1; lock_boot_n = 1'b1; in_boot = 1'b0;
        irq_index = '0; exp_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 vec_base", vec_base, 16'h0);
        chk("R1 irq_block", irq_block, 1'b0);

        // R8 upper bits stored; R7 select ignored outside window
        wr(8'hFC);
        chk("R8 misc store", rd_data, 8'hFC);
        wr(8'hAA);
        chk("R7 sel outside window", rd_data, 8'hA8);
        chk("R7 no hold", irq_block, 1'b0);

        // R5 idle window lasts exactly 4 cycles
        wr(8'h01);
        for (int k = 0; k < 4; k++) begin
            chk("R5 unlock open", rd_data[0], 1'b1);
            chk("R4 hold while open", irq_block, 1'b1);
            @(negedge clk);
        end
        chk("R5 unlock expired", rd_data[0], 1'b0);
        chk("R5 hold ended", irq_block, 1'b0);

        // R3/R7 window boundary sweep
        for (int d = 0; d < 6; d++) begin
            logic [5:0] tag;
            logic tgt;
            tag = 6'(d + 1);
            wr({tag, exp_sel, 1'b1});
            chk("R4 unlock set", rd_data[0], 1'b1);
            chk("R7 unlock write keeps sel", rd_data[1], exp_sel);
            repeat (d) @(negedge clk);
            tgt = ~exp_sel;
            wr({tag, tgt, 1'b0});
            if (d <= 3) begin
                exp_sel = tgt;
                chk("R3 accepted write", rd_data, {tag, exp_sel, 1'b0});
                chk("R6 hold after write", irq_block, 1'b1);
                @(negedge clk);
                chk("R6 hold waits", irq_block, 1'b1);
                pulse_done();
                chk("R6 hold released", irq_block, 1'b0);
            end else begin
                chk("R7 late write ignored", rd_data, {tag, exp_sel, 1'b0});
                chk("R5 no hold after expiry", irq_block, 1'b0);
            end
        end

        // R12 re-arming restarts the window
        begin
            logic tgt;
            wr(8'h01);
            repeat (3) @(negedge clk);
            wr(8'h01);
            repeat (3) @(negedge clk);
            tgt = ~exp_sel;
            wr({6'h0, tgt, 1'b0});
            exp_sel = tgt;
            chk("R12 rearmed window accepts", rd_data[1], exp_sel);
            pulse_done();
        end

        // R2/R9 address sweep
        for (int s = 0; s < 2; s++) begin
            set_sel(s[0]);
            for (int bs = 0; bs < 4; bs++) begin
                logic [15:0] eb;
                boot_size = bs[1:0];
                eb = (s == 1) ? 16'(32'h10000 - (32'h1000 >> bs)) : 16'h0;
                #1;
                chk("R2 vec_base", vec_base, eb);
                for (int ix = 0; ix < 64; ix++) begin
                    irq_index = ix[5:0];
                    #1;
                    chk("R9 vec_addr", vec_addr, 16'(eb + 2 * ix));
                end
            end
        end

        // R10 R11 lock gating sweep
        for (int s = 0; s < 2; s++) begin
            set_sel(s[0]);
            for (int c = 0; c < 8; c++) begin
                logic e;
                in_boot     = c[2];
                lock_app_n  = c[1];
                lock_boot_n = c[0];
                e = (s == 1 && !c[1] && !c[2]) || (s == 0 && !c[0] && c[2]);
                #1;
                chk("R10 R11 lock hold", irq_block, e);
                @(negedge clk);
            end
            lock_app_n = 1'b1; lock_boot_n = 1'b1; in_boot = 1'b0;
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule